// File: doc/BRIEF.md
# Two-Byte Display Memory Write Sequencer

This block sits behind the byte-wide data register of a character and graphic display controller. Software sends bytes one at a time. Each byte is either a data byte or an address byte. The block pairs data bytes into 16-bit words, high byte first. It then issues one word write, with its address, to either the text memory or the graphic memory.

The graphic memory is 64 rows by 256 bits, which is 16 words per row. Its address is set by two graphic-address bytes: the row (vertical) first, then the word column (horizontal). After every completed word, the column advances, and a full row carries into the next row. The text memory holds 64 words, arranged as 4 lines of 16 positions, and its position also advances after each word. Every text word also gets a tag naming the glyph source it selects. The memory arrays and the font lookup are outside this block.

Top module: `dispword_seq`

## Requirements
- R1: After reset, `wr_strobe` is 0, `glyph` is 0, the target is the text memory at position 0, and the next data byte is taken as a high byte.
- R2: Two data bytes (`wr_kind`=0) form one word `{first, second}`. One cycle after the second byte is accepted, `wr_strobe` pulses for exactly one cycle with that word on `wr_word`. A lone first byte gives no strobe.
- R3: A text-address byte (`wr_kind`=1) selects the text memory and sets the position to `wr_byte[5:0]`. Each text word then advances the position by one, and position 63 wraps to 0. `wr_gfx`=0 for text words.
- R4: Two graphic-address bytes (`wr_kind`=2) set the row from `wr_byte[5:0]` (first byte) and the column from `wr_byte[3:0]` (second byte). Graphic words then go out with `wr_gfx`=1 and `wr_addr` = row*16 + column.
- R5: After each graphic word, the column advances. Column 15 wraps to 0 and increments the row, and address 1023 wraps to 0.
- R6: Any address byte (`wr_kind` 1 or 2) discards a pending high byte, so the next data byte is again a high byte.
- R7: A text word equal to 0000h, 0002h, 0004h or 0006h gets `glyph`=1 (user-defined glyph).
- R8: A text word whose two bytes are both within 02h..7Fh gets `glyph`=2 (pair of half-width glyphs).
- R9: With `FULL_SET`=0, a text word within A140h..D75Fh gets `glyph`=3 (full-width glyph). With `FULL_SET`=1, the range is A1A0h..F7FFh instead.
- R10: A text word that matches none of R7..R9 gets `glyph`=4 (invalid). Graphic words always carry `glyph`=0.
- R11: If the row byte has been written and any other accepted byte (data or text address) comes before the column byte, the row is dropped. The next graphic-address byte is then taken as a row again, and the target memory is left unchanged.
- R12: A byte with `wr_kind`=3 has no effect. It causes no strobe, keeps a pending high byte and keeps every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write valid |
| wr_kind | input | 2 | 0 data, 1 text address, 2 graphic address, 3 no effect |
| wr_byte | input | 8 | Byte value |
| wr_strobe | output | 1 | One-cycle word write strobe |
| wr_gfx | output | 1 | 1 = graphic memory, 0 = text memory |
| wr_addr | output | 10 | Word address (text position zero-extended) |
| wr_word | output | 16 | Assembled word |
| glyph | output | 3 | 0 graphic, 1 user, 2 half pair, 3 full, 4 invalid |

## Verification
Text words are driven at the exact edges of each code range: A13Fh/A140h, D75Fh/D760h, the four user codes against 0001h and 0008h, and half-width pairs against a pair with one byte out of range. These separate a classifier that is off by one or has its priorities mixed up. Graphic runs start at column 15 and at address 1023, which shows whether the column carry and the full wrap are correct. Address bytes and no-effect bytes are placed between the two halves of a word, and between a row byte and its column byte. This tells apart a phase that resets on address writes from one that does not.

// File: rtl/dispword_seq.sv
module dispword_seq #(
  parameter int Y_W      = 6,
  parameter int X_W      = 4,
  parameter int T_W      = 6,
  parameter bit FULL_SET = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_kind,
  input  logic [7:0]           wr_byte,
  output logic                 wr_strobe,
  output logic                 wr_gfx,
  output logic [Y_W+X_W-1:0]   wr_addr,
  output logic [15:0]          wr_word,
  output logic [2:0]           glyph
);
  localparam int A_W = Y_W + X_W;
  localparam logic [15:0] F_LO = FULL_SET ? 16'hA1A0 : 16'hA140;
  localparam logic [15:0] F_HI = FULL_SET ? 16'hF7FF : 16'hD75F;
  localparam logic [2:0] G_NONE = 3'd0, G_USER = 3'd1, G_HALF = 3'd2,
                         G_FULL = 3'd3, G_BAD = 3'd4;

  logic [Y_W-1:0] gy, gy_pend;
  logic [X_W-1:0] gx;
  logic [T_W-1:0] tpos;
  logic           tgt_gfx, hi_ph, a_ph;
  logic [7:0]     hi_q;

  wire wd   = wr_en && wr_kind == 2'd0;
  wire wt   = wr_en && wr_kind == 2'd1;
  wire wg   = wr_en && wr_kind == 2'd2;
  wire done = wd && hi_ph;
  wire [15:0]    word_n = {hi_q, wr_byte};
  wire [A_W-1:0] gaddr  = {gy, gx};

  wire is_user  = word_n[15:3] == 13'd0 && !word_n[0];
  wire half_hi  = hi_q >= 8'h02 && hi_q <= 8'h7F;
  wire half_lo  = wr_byte >= 8'h02 && wr_byte <= 8'h7F;
  wire is_full  = word_n >= F_LO && word_n <= F_HI;

  logic [2:0] cls;
  always_comb begin
    if (is_user)                cls = G_USER;
    else if (half_hi && half_lo) cls = G_HALF;
    else if (is_full)           cls = G_FULL;
    else                        cls = G_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_strobe <= 1'b0;
      wr_gfx    <= 1'b0;
      wr_addr   <= '0;
      wr_word   <= '0;
      glyph     <= G_NONE;
      gy        <= '0;
      gy_pend   <= '0;
      gx        <= '0;
      tpos      <= '0;
      tgt_gfx   <= 1'b0;
      hi_ph     <= 1'b0;
      a_ph      <= 1'b0;
      hi_q      <= '0;
    end else begin
      wr_strobe <= done;
      if (done) begin
        wr_word <= word_n;
        wr_gfx  <= tgt_gfx;
        wr_addr <= tgt_gfx ? gaddr : A_W'(tpos);
        glyph   <= tgt_gfx ? G_NONE : cls;
        if (tgt_gfx) {gy, gx} <= gaddr + 1'b1;
        else         tpos     <= tpos + 1'b1;
      end
      if (wd) begin
        hi_ph <= !hi_ph;
        if (!hi_ph) hi_q <= wr_byte;
      end
      if (wt) begin
        tpos    <= wr_byte[T_W-1:0];
        tgt_gfx <= 1'b0;
        hi_ph   <= 1'b0;
      end
      if (wg) begin
        hi_ph <= 1'b0;
        a_ph  <= !a_ph;
        if (!a_ph) gy_pend <= wr_byte[Y_W-1:0];
        else begin
          gy      <= gy_pend;
          gx      <= wr_byte[X_W-1:0];
          tgt_gfx <= 1'b1;
        end
      end else if (wd || wt) begin
        a_ph <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dispword_seq_chk.sv
module dispword_seq_chk #(
  parameter int A_W = 10,
  parameter int T_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [1:0]     wr_kind,
  input logic           wr_strobe,
  input logic           wr_gfx,
  input logic [A_W-1:0] wr_addr,
  input logic [2:0]     glyph
);
  logic           seen, touched, last_gfx;
  logic [A_W-1:0] last_addr;
  logic [T_W-1:0] tnext;
  assign tnext = last_addr[T_W-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; touched <= 1'b0; last_gfx <= 1'b0; last_addr <= '0;
    end else begin
      if (wr_strobe) begin
        seen <= 1'b1; touched <= 1'b0; last_gfx <= wr_gfx; last_addr <= wr_addr;
      end
      if (wr_en && (wr_kind == 2'd1 || wr_kind == 2'd2)) touched <= 1'b1;
    end
  end

  p_strobe_after_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(wr_en && wr_kind == 2'd0));
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);
  p_gfx_no_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_gfx) |-> glyph == 3'd0);
  p_text_tag_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !wr_gfx) |-> (glyph != 3'd0 && glyph <= 3'd4));
  p_gfx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && seen && !touched && wr_gfx && last_gfx) |-> wr_addr == last_addr + 1'b1);
  p_text_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && seen && !touched && !wr_gfx && !last_gfx) |-> wr_addr == A_W'(tnext));
endmodule

bind dispword_seq dispword_seq_chk #(.A_W(Y_W + X_W), .T_W(T_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
  .wr_strobe(wr_strobe), .wr_gfx(wr_gfx), .wr_addr(wr_addr), .glyph(glyph)
);

// File: tb/sim_dispword_seq.sv
module sim_dispword_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = 2'd0;
  logic [7:0]  wr_byte = 8'd0;
  logic        wr_strobe, wr_gfx;
  logic [9:0]  wr_addr;
  logic [15:0] wr_word;
  logic [2:0]  glyph;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dispword_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_byte(wr_byte), .wr_strobe(wr_strobe), .wr_gfx(wr_gfx), .wr_addr(wr_addr),
    .wr_word(wr_word), .glyph(glyph));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_word(input logic [7:0] hi, input logic [7:0] lo, input logic g,
                          input logic [9:0] a, input logic [2:0] t, input string rq);
    wr(2'd0, hi);
    chk(!wr_strobe, "R2", 32'(wr_strobe), 32'd0);
    wr(2'd0, lo);
    chk(wr_strobe, "R2", 32'(wr_strobe), 32'd1);
    chk(wr_word == {hi, lo}, "R2", 32'(wr_word), 32'({hi, lo}));
    chk(wr_gfx == g, rq, 32'(wr_gfx), 32'(g));
    chk(wr_addr == a, rq, 32'(wr_addr), 32'(a));
    chk(glyph == t, rq, 32'(glyph), 32'(t));
  endtask

  task automatic t_reset;
    chk(!wr_strobe && glyph == 3'd0, "R1", 32'({wr_strobe, glyph}), 32'd0);
    put_word(8'h12, 8'h34, 1'b0, 10'd0, 3'd2, "R1");
  endtask

  task automatic t_text_wrap;
    wr(2'd1, 8'h3E);
    put_word(8'h41, 8'h42, 1'b0, 10'd62, 3'd2, "R3");
    put_word(8'h43, 8'h44, 1'b0, 10'd63, 3'd2, "R3");
    put_word(8'h45, 8'h46, 1'b0, 10'd0,  3'd2, "R3");
  endtask

  task automatic t_user;
    wr(2'd1, 8'h08);
    put_word(8'h00, 8'h00, 1'b0, 10'd8,  3'd1, "R7");
    put_word(8'h00, 8'h02, 1'b0, 10'd9,  3'd1, "R7");
    put_word(8'h00, 8'h04, 1'b0, 10'd10, 3'd1, "R7");
    put_word(8'h00, 8'h06, 1'b0, 10'd11, 3'd1, "R7");
    put_word(8'h00, 8'h08, 1'b0, 10'd12, 3'd4, "R10");
    put_word(8'h00, 8'h01, 1'b0, 10'd13, 3'd4, "R10");
  endtask

  task automatic t_half;
    wr(2'd1, 8'h20);
    put_word(8'h02, 8'h7F, 1'b0, 10'd32, 3'd2, "R8");
    put_word(8'h7F, 8'h02, 1'b0, 10'd33, 3'd2, "R8");
    put_word(8'h01, 8'h41, 1'b0, 10'd34, 3'd4, "R8");
    put_word(8'h41, 8'h80, 1'b0, 10'd35, 3'd4, "R8");
  endtask

  task automatic t_full;
    wr(2'd1, 8'h28);
    put_word(8'hA1, 8'h40, 1'b0, 10'd40, 3'd3, "R9");
    put_word(8'hA1, 8'h3F, 1'b0, 10'd41, 3'd4, "R9");
    put_word(8'hD7, 8'h5F, 1'b0, 10'd42, 3'd3, "R9");
    put_word(8'hD7, 8'h60, 1'b0, 10'd43, 3'd4, "R9");
    put_word(8'hF7, 8'hFF, 1'b0, 10'd44, 3'd4, "R9");
  endtask

  task automatic t_gfx;
    wr(2'd2, 8'd5); wr(2'd2, 8'd3);
    put_word(8'hAB, 8'hCD, 1'b1, 10'd83, 3'd0, "R4");
    wr(2'd2, 8'd5); wr(2'd2, 8'd15);
    put_word(8'h01, 8'h02, 1'b1, 10'd95, 3'd0, "R5");
    put_word(8'h03, 8'h04, 1'b1, 10'd96, 3'd0, "R5");
    wr(2'd2, 8'd63); wr(2'd2, 8'd15);
    put_word(8'h05, 8'h06, 1'b1, 10'd1023, 3'd0, "R5");
    put_word(8'h07, 8'h08, 1'b1, 10'd0, 3'd0, "R5");
  endtask

  task automatic t_phase;
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h10);
    put_word(8'h22, 8'h33, 1'b0, 10'd16, 3'd2, "R6");
    wr(2'd0, 8'h44);
    wr(2'd2, 8'd1); wr(2'd2, 8'd2);
    put_word(8'h55, 8'h66, 1'b1, 10'd18, 3'd0, "R6");
  endtask

  task automatic t_abandon;
    wr(2'd1, 8'h05);
    wr(2'd2, 8'd7);
    put_word(8'h30, 8'h31, 1'b0, 10'd5, 3'd2, "R11");
    wr(2'd2, 8'd9); wr(2'd2, 8'd1);
    put_word(8'h32, 8'h33, 1'b1, 10'd145, 3'd0, "R11");
  endtask

  task automatic t_ignored;
    wr(2'd1, 8'h30);
    wr(2'd0, 8'hA1);
    wr(2'd3, 8'h00);
    chk(!wr_strobe, "R12", 32'(wr_strobe), 32'd0);
    wr(2'd0, 8'h40);
    chk(wr_strobe && wr_word == 16'hA140, "R12", 32'(wr_word), 32'hA140);
    chk(wr_addr == 10'd48 && glyph == 3'd3, "R12", 32'({wr_addr, glyph}), 32'({10'd48, 3'd3}));
    wr(2'd3, 8'h3F);
    put_word(8'h50, 8'h51, 1'b0, 10'd49, 3'd2, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_text_wrap;
    t_user;
    t_half;
    t_full;
    t_gfx;
    t_phase;
    t_abandon;
    t_ignored;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2 actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule